// File: doc/BRIEF.md
# Hexadecimal Floating-Point Digit Divider

This block divides one single-precision base-16 floating-point number by another. A word carries a sign bit, a seven-bit exponent and a six-digit hexadecimal fraction. Both operands are brought to normal form on entry. The block then develops the quotient one hex digit per step. Each digit is found by counting how many times the divisor can be subtracted from the running remainder, at one subtraction per clock. A rounding decision is taken from the final remainder. The block packs the result word and a four-bit condition code.

The surrounding datapath pulses `start_i` with both operands present. It then waits for `done_o`. On that cycle `quo_o` and `cc_o` carry the outcome. `wr_o` tells whether the destination register is to be written. Some operands settle before any digit is developed: a zero divisor, a zero dividend, and an exponent that is already outside the legal range. These cases finish in a fixed short time. An ordinary division takes a number of cycles that depends on the data, with a known upper bound.

Top module: `hexdiv_core`

## Requirements
- R1: While reset is asserted, and after it is released, `done_o`, `wr_o`, `cc_o` and `quo_o` are all zero until the first division completes.
- R2: A word is laid out as sign in bit 31, an exponent in bits 30:24 with a bias of 64, and a fraction of six hex digits in bits 23:0. A nonzero input fraction with leading zero digits is shifted left one digit at a time, and the exponent is lowered by one for each digit. A zero fraction is treated as zero whatever its sign and exponent.
- R3: A zero divisor, including 0/0, completes with `cc_o` = 4'b1100 and `wr_o` low, and `quo_o` keeps its previous value. The condition-code bits are bit 3 = C, bit 2 = V, bit 1 = G, bit 0 = L.
- R4: A zero dividend divided by a nonzero divisor gives `quo_o` = 0 with `cc_o` = 4'b0000 and `wr_o` high.
- R5: For in-range results, the sign is the XOR of the operand signs. The exponent is e1 − e2 + 64, plus one when the dividend fraction is not below the divisor fraction. The fraction is the six-digit quotient. `cc_o` is 4'b0010 for a positive result and 4'b0001 for a negative one.
- R6: When twice the remainder left after the sixth digit is at least the divisor fraction, one is added to the quotient. A carry out of the top digit shifts the fraction right one digit and raises the exponent.
- R7: An exponent above 127, whether before or after the one-digit adjustment, saturates the result. A positive result becomes 32'h7FFF_FFFF with `cc_o` = 4'b0110, and a negative one becomes 32'hFFFF_FFFF with `cc_o` = 4'b0101.
- R8: An initial exponent below 0 gives `quo_o` = 0 with `cc_o` = 4'b0100 and `wr_o` high.
- R9: `done_o` is a single-cycle pulse, and `wr_o` is high only in a cycle where `done_o` is high.
- R10: The cases settled without digit development (R3, R4, R7, R8) raise `done_o` two clock edges after the edge that samples `start_i`.
- R11: A `start_i` pulse that arrives while a division is in progress is ignored. The running division completes with its own operands, and no second completion follows.
- R12: No quotient digit takes more than 15 subtractions, so any division raises `done_o` within 99 edges of the sampling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a division with the operands present |
| dvd_i | input | 32 | Packed dividend |
| dvs_i | input | 32 | Packed divisor |
| quo_o | output | 32 | Packed quotient, valid with `done_o` |
| cc_o | output | 4 | Condition code {C, V, G, L} |
| wr_o | output | 1 | Destination write strobe |
| done_o | output | 1 | Completion pulse |

## Verification
A wrong remainder or a misplaced quotient shift shows up as a wrong fraction at `quo_o` on the very completion that used it. A wrong rounding comparison shows up only in the last fraction bit, so the 2/3 case, which rounds, sits next to the 1/3 case, which truncates. A sticking digit counter or a lost subtraction shows up as wrong digits and as a completion that arrives later than the 99-edge bound. Mistakes in the exponent path show up one exponent step away from each limit: at 127 versus 128 after the adjustment, and at 0 versus −1. Those limits are driven directly.

// File: rtl/hexdiv_pkg.sv
package hexdiv_pkg;

   // Condition-code bits: [3]=C, [2]=V, [1]=G, [0]=L
   localparam logic [3:0] CC_NONE  = 4'b0000;
   localparam logic [3:0] CC_LESS  = 4'b0001;
   localparam logic [3:0] CC_GREAT = 4'b0010;
   localparam logic [3:0] CC_OVF   = 4'b0100;
   localparam logic [3:0] CC_CARRY = 4'b1000;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PREP,
      ST_RUN
   } hd_state_e;

endpackage

// File: rtl/hexdiv_unpack.sv
// Splits a packed word and brings the fraction to normal form (R2).
module hexdiv_unpack #(
   parameter int DIGITS = 6,
   parameter int EXP_W  = 7,
   localparam int FW    = 4 * DIGITS,
   localparam int W     = 1 + EXP_W + FW,
   localparam int ESW   = EXP_W + 3
) (
   input  logic [W-1:0]          word_i,
   output logic                  zero_o,
   output logic                  sign_o,
   output logic signed [ESW-1:0] exp_o,
   output logic [FW-1:0]         frac_o
);
   localparam int LZW = $clog2(DIGITS + 1);

   logic [FW-1:0]     raw;
   logic [DIGITS-1:0] nz;
   logic [LZW-1:0]    lead;
   logic              found;

   assign raw = word_i[FW-1:0];

   // nz[i] flags hex digit i, counted from the most significant end
   for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      assign nz[g] = |raw[FW-1-4*g -: 4];
   end

   always_comb begin
      lead  = '0;
      found = 1'b0;
      for (int i = 0; i < DIGITS; i++) begin
         if (!found && nz[i]) begin
            lead  = LZW'(i);
            found = 1'b1;
         end
      end
   end

   always_comb begin
      zero_o = ~found;
      if (found) begin
         sign_o = word_i[W-1];
         exp_o  = $signed({3'b000, word_i[W-2 -: EXP_W]})
                - $signed({{(ESW-LZW){1'b0}}, lead});
         frac_o = raw << {lead, 2'b00};
      end else begin
         sign_o = 1'b0;
         exp_o  = '0;
         frac_o = '0;
      end
   end

endmodule

// File: rtl/hexdiv_digits.sv
// Digit recurrence: one subtraction or one digit shift per clock.
module hexdiv_digits #(
   parameter int DIGITS = 6,
   localparam int FW    = 4 * DIGITS,
   localparam int RW    = FW + 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [RW-1:0] rem_i,
   input  logic [FW-1:0] div_i,
   output logic [FW-1:0] quo_o,
   output logic [RW-1:0] rem_o,
   output logic          done_o,
   output logic          sub_fire_o,
   output logic [3:0]    sub_cnt_o
);
   localparam int DCW = $clog2(DIGITS);

   if (DIGITS < 2) begin : g_bad_digits
      $error("hexdiv_digits: DIGITS must be at least 2");
   end

   logic           run_q;
   logic           done_q;
   logic [DCW-1:0] dig_q;
   logic [3:0]     cnt_q;
   logic [RW-1:0]  rem_q;
   logic [FW-1:0]  div_q;
   logic [FW-1:0]  quo_q;
   logic           fits;
   logic           last;

   assign fits = rem_q >= {4'b0000, div_q};
   assign last = dig_q == DCW'(DIGITS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         done_q <= 1'b0;
         dig_q  <= '0;
         cnt_q  <= '0;
         rem_q  <= '0;
         div_q  <= '0;
         quo_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (load_i) begin
            rem_q <= rem_i;
            div_q <= div_i;
            quo_q <= '0;
            dig_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b1;
         end else if (run_q) begin
            if (fits) begin
               rem_q <= rem_q - {4'b0000, div_q};
               quo_q <= quo_q + FW'(1);
               cnt_q <= cnt_q + 4'd1;
            end else begin
               rem_q <= rem_q << 4;
               cnt_q <= '0;
               if (last) begin
                  run_q  <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  dig_q <= dig_q + DCW'(1);
                  quo_q <= quo_q << 4;
               end
            end
         end
      end
   end

   assign quo_o      = quo_q;
   assign rem_o      = rem_q;
   assign done_o     = done_q;
   assign sub_fire_o = run_q & fits;
   assign sub_cnt_o  = cnt_q;

endmodule

// File: rtl/hexdiv_pack.sv
// Rounding, carry renormalization, range check and packing.
module hexdiv_pack #(
   parameter int DIGITS   = 6,
   parameter int EXP_W    = 7,
   parameter bit ROUND_EN = 1'b1,
   localparam int FW      = 4 * DIGITS,
   localparam int W       = 1 + EXP_W + FW,
   localparam int ESW     = EXP_W + 3
) (
   input  logic                  sign_i,
   input  logic signed [ESW-1:0] exp_i,
   input  logic [FW-1:0]         quo_i,
   input  logic                  round_i,
   output logic [W-1:0]          word_o,
   output logic [3:0]            cc_o
);
   import hexdiv_pkg::*;

   localparam int EMAX = (1 << EXP_W) - 1;
   localparam logic signed [ESW-1:0] EMAX_S = EMAX[ESW-1:0];
   localparam logic signed [ESW-1:0] ONE_S  = 1;

   logic                  inc;
   logic [FW:0]           sum;
   logic [FW-1:0]         frac;
   logic signed [ESW-1:0] exp_f;

   if (ROUND_EN) begin : g_round
      assign inc = round_i;
   end else begin : g_trunc
      assign inc = 1'b0;
   end

   assign sum   = {1'b0, quo_i} + {{FW{1'b0}}, inc};
   assign frac  = sum[FW] ? {3'b000, sum[FW:4]} : sum[FW-1:0];
   assign exp_f = sum[FW] ? exp_i + ONE_S : exp_i;

   always_comb begin
      if (exp_f > EMAX_S) begin
         word_o = {sign_i, {(W-1){1'b1}}};
         cc_o   = CC_OVF | (sign_i ? CC_LESS : CC_GREAT);
      end else begin
         word_o = {sign_i, exp_f[EXP_W-1:0], frac};
         cc_o   = sign_i ? CC_LESS : CC_GREAT;
      end
   end

endmodule

// File: rtl/hexdiv_core.sv
module hexdiv_core #(
   parameter int DIGITS = 6,
   parameter int EXP_W  = 7,
   localparam int W     = 1 + EXP_W + 4 * DIGITS
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] dvd_i,
   input  logic [W-1:0] dvs_i,
   output logic [W-1:0] quo_o,
   output logic [3:0]   cc_o,
   output logic         wr_o,
   output logic         done_o
);
   import hexdiv_pkg::*;

   localparam int FW   = 4 * DIGITS;
   localparam int RW   = FW + 4;
   localparam int ESW  = EXP_W + 3;
   localparam int EMAX = (1 << EXP_W) - 1;
   localparam int BIAS = 1 << (EXP_W - 1);
   localparam logic signed [ESW-1:0] EMAX_S = EMAX[ESW-1:0];
   localparam logic signed [ESW-1:0] BIAS_S = BIAS[ESW-1:0];
   localparam logic signed [ESW-1:0] ONE_S  = 1;

   if (EXP_W < 2) begin : g_bad_exp
      $error("hexdiv_core: EXP_W must be at least 2");
   end
   if (DIGITS < 2) begin : g_bad_dig
      $error("hexdiv_core: DIGITS must be at least 2");
   end

   hd_state_e st_q;
   logic [W-1:0] a_q;
   logic [W-1:0] b_q;
   logic         sign_q;
   logic signed [ESW-1:0] exp_q;

   // operand unpacking
   logic                  ua_zero, ub_zero, ua_sign, ub_sign;
   logic signed [ESW-1:0] ua_exp, ub_exp;
   logic [FW-1:0]         ua_frac, ub_frac;

   hexdiv_unpack #(.DIGITS(DIGITS), .EXP_W(EXP_W)) u_unp_a (
      .word_i (a_q),
      .zero_o (ua_zero),
      .sign_o (ua_sign),
      .exp_o  (ua_exp),
      .frac_o (ua_frac)
   );

   hexdiv_unpack #(.DIGITS(DIGITS), .EXP_W(EXP_W)) u_unp_b (
      .word_i (b_q),
      .zero_o (ub_zero),
      .sign_o (ub_sign),
      .exp_o  (ub_exp),
      .frac_o (ub_frac)
   );

   // exponent and seed remainder
   logic                  sgn;
   logic                  f_lt;
   logic signed [ESW-1:0] e_base;
   logic signed [ESW-1:0] e_adj;
   logic [RW-1:0]         rem_seed;
   logic                  go;
   logic [W-1:0]          ovf_word;

   assign sgn      = ua_sign ^ ub_sign;
   assign f_lt     = ua_frac < ub_frac;
   assign e_base   = ua_exp - ub_exp + BIAS_S;
   assign e_adj    = f_lt ? e_base : e_base + ONE_S;
   assign rem_seed = f_lt ? {ua_frac, 4'b0000} : {4'b0000, ua_frac};
   assign ovf_word = {sgn, {(W-1){1'b1}}};
   assign go       = !ub_zero && !ua_zero && !e_base[ESW-1] && !(e_adj > EMAX_S);

   // digit engine
   logic          eng_load;
   logic [FW-1:0] eng_quo;
   logic [RW-1:0] eng_rem;
   logic          eng_done;
   logic          sub_fire_w;
   logic [3:0]    sub_cnt_w;

   assign eng_load = (st_q == ST_PREP) && go;

   hexdiv_digits #(.DIGITS(DIGITS)) u_digits (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (eng_load),
      .rem_i      (rem_seed),
      .div_i      (ub_frac),
      .quo_o      (eng_quo),
      .rem_o      (eng_rem),
      .done_o     (eng_done),
      .sub_fire_o (sub_fire_w),
      .sub_cnt_o  (sub_cnt_w)
   );

   // round bit: final remainder at least eight divisor fractions
   logic          round_bit;
   logic [W-1:0]  pk_word;
   logic [3:0]    pk_cc;

   assign round_bit = eng_rem >= {1'b0, ub_frac, 3'b000};

   hexdiv_pack #(.DIGITS(DIGITS), .EXP_W(EXP_W), .ROUND_EN(1'b1)) u_pack (
      .sign_i  (sign_q),
      .exp_i   (exp_q),
      .quo_i   (eng_quo),
      .round_i (round_bit),
      .word_o  (pk_word),
      .cc_o    (pk_cc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         a_q    <= '0;
         b_q    <= '0;
         sign_q <= 1'b0;
         exp_q  <= '0;
         quo_o  <= '0;
         cc_o   <= CC_NONE;
         wr_o   <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         wr_o   <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  a_q  <= dvd_i;
                  b_q  <= dvs_i;
                  st_q <= ST_PREP;
               end
            end
            ST_PREP: begin
               st_q <= ST_IDLE;
               if (ub_zero) begin
                  done_o <= 1'b1;
                  cc_o   <= CC_CARRY | CC_OVF;
               end else if (ua_zero) begin
                  done_o <= 1'b1;
                  wr_o   <= 1'b1;
                  quo_o  <= '0;
                  cc_o   <= CC_NONE;
               end else if (e_base[ESW-1]) begin
                  done_o <= 1'b1;
                  wr_o   <= 1'b1;
                  quo_o  <= '0;
                  cc_o   <= CC_OVF;
               end else if (e_adj > EMAX_S) begin
                  done_o <= 1'b1;
                  wr_o   <= 1'b1;
                  quo_o  <= ovf_word;
                  cc_o   <= CC_OVF | (sgn ? CC_LESS : CC_GREAT);
               end else begin
                  sign_q <= sgn;
                  exp_q  <= e_adj;
                  st_q   <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (eng_done) begin
                  done_o <= 1'b1;
                  wr_o   <= 1'b1;
                  quo_o  <= pk_word;
                  cc_o   <= pk_cc;
                  st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/hexdiv_core_chk.sv
module hexdiv_core_chk #(
   parameter int DIGITS = 6,
   parameter int EXP_W  = 7,
   localparam int FW    = 4 * DIGITS,
   localparam int W     = 1 + EXP_W + FW
) (
   input logic         clk,
   input logic         rst_n,
   input logic         done_o,
   input logic         wr_o,
   input logic [3:0]   cc_o,
   input logic [W-1:0] quo_o,
   input logic         sub_fire_i,
   input logic [3:0]   sub_cnt_i
);

   assert_write_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_o |-> done_o);

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_skip_only_divzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !wr_o) |-> (cc_o == 4'b1100));

   assert_zero_word_cc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && wr_o && quo_o == '0) |-> (cc_o == 4'b0000 || cc_o == 4'b0100));

   assert_ovf_pos_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cc_o == 4'b0110) |-> (quo_o == {1'b0, {(W-1){1'b1}}}));

   assert_ovf_neg_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && cc_o == 4'b0101) |-> (quo_o == {W{1'b1}}));

   assert_sign_cc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && wr_o && !cc_o[2] && quo_o != '0)
         |-> (cc_o == (quo_o[W-1] ? 4'b0001 : 4'b0010)));

   assert_lead_digit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && wr_o && !cc_o[2] && quo_o != '0) |-> (quo_o[FW-1 -: 4] != 4'h0));

   assert_digit_limit_R12: assert property (@(posedge clk) disable iff (!rst_n)
      sub_fire_i |-> (sub_cnt_i != 4'hF));

endmodule

bind hexdiv_core hexdiv_core_chk #(.DIGITS(DIGITS), .EXP_W(EXP_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .done_o     (done_o),
   .wr_o       (wr_o),
   .cc_o       (cc_o),
   .quo_o      (quo_o),
   .sub_fire_i (sub_fire_w),
   .sub_cnt_i  (sub_cnt_w)
);

// File: tb/hexdiv_core_test.sv
`timescale 1ns/1ps
module hexdiv_core_test;

   logic        clk;
   logic        rst_n;
   logic        start;
   logic [31:0] dvd;
   logic [31:0] dvs;
   logic [31:0] quo_o;
   logic [3:0]  cc_o;
   logic        wr_o;
   logic        done_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] last_res = 32'h0;

   hexdiv_core uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .dvd_i   (dvd),
      .dvs_i   (dvs),
      .quo_o   (quo_o),
      .cc_o    (cc_o),
      .wr_o    (wr_o),
      .done_o  (done_o)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic unpack_ref(input logic [31:0] x, output bit z, output bit s,
                             output int e, output longint unsigned f);
      f = 64'(x[23:0]);
      if (f == 0) begin
         z = 1; s = 0; e = 0;
      end else begin
         z = 0; s = x[31]; e = int'(x[30:24]);
         while (f < 64'h100000) begin
            f = f << 4;
            e--;
         end
      end
   endtask

   task automatic model(input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] r, output logic [3:0] c,
                        output bit w, output bit spec, output string tag);
      bit za, zb, sa, sb, s;
      int ea, eb, e;
      longint unsigned fa, fb, rem, q, m;
      unpack_ref(a, za, sa, ea, fa);
      unpack_ref(b, zb, sb, eb, fb);
      spec = 1; w = 1; r = 32'h0; c = 4'b0000; tag = "R5";
      if (zb) begin
         r = last_res; c = 4'b1100; w = 0; tag = "R3";
      end else if (za) begin
         tag = "R4";
      end else begin
         s = sa ^ sb;
         e = ea - eb + 64;
         if (e < 0) begin
            c = 4'b0100; tag = "R8";
         end else begin
            if (fa < fb) rem = fa << 4;
            else begin
               rem = fa; e++;
            end
            if (e > 127) begin
               r = s ? 32'hFFFF_FFFF : 32'h7FFF_FFFF;
               c = s ? 4'b0101 : 4'b0110; tag = "R7";
            end else begin
               spec = 0;
               q = (rem << 20) / fb;
               m = (rem << 20) % fb;
               if (2 * m >= fb) begin
                  q++; tag = "R6";
               end
               if (q >= 64'h1000000) begin
                  q = q >> 4; e++;
               end
               if (e > 127) begin
                  r = s ? 32'hFFFF_FFFF : 32'h7FFF_FFFF;
                  c = s ? 4'b0101 : 4'b0110; tag = "R7";
               end else begin
                  r = {s, 7'(e), q[23:0]};
                  c = s ? 4'b0001 : 4'b0010;
               end
            end
         end
      end
   endtask

   task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                         input bit poke_req, input string tag_ovr);
      logic [31:0] r;
      logic [3:0]  c;
      bit          w, spec, poke;
      string       tag;
      int          cyc;
      bit          quiet;
      model(a, b, r, c, w, spec, tag);
      if (tag_ovr != "") tag = tag_ovr;
      poke = poke_req && !spec;
      @(negedge clk);
      dvd = a; dvs = b; start = 1'b1;
      cyc = 0;
      do begin
         @(negedge clk);
         start = 1'b0;
         cyc++;
         if (poke && cyc == 3) begin
            start = 1'b1;
            dvd = ~a;
            dvs = b ^ 32'h00F0_0000;
         end
      end while (!done_o && cyc < 400);
      start = 1'b0;
      check(done_o == 1'b1, "R12", "completion seen", 64'(cyc), 64'd99);
      check(quo_o == r && cc_o == c && wr_o == w, tag, "result/cc/wr",
            {27'h0, quo_o, cc_o, wr_o}, {27'h0, r, c, w});
      if (spec) check(cyc == 2, "R10", "settled-case latency", 64'(cyc), 64'd2);
      else      check(cyc <= 99, "R12", "division latency", 64'(cyc), 64'd99);
      if (w) last_res = r;
      @(negedge clk);
      check(!done_o && !wr_o, "R9", "pulse width",
            {62'h0, done_o, wr_o}, 64'h0);
      if (poke) begin
         quiet = 1;
         for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (done_o) quiet = 0;
         end
         check(quiet, "R11", "no completion from ignored start", 64'(!quiet), 64'h0);
      end
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] a, b;
      void'($urandom(32'd24681));
      rst_n = 1'b0; start = 1'b0; dvd = '0; dvs = '0;
      repeat (3) @(negedge clk);
      check(quo_o == 0 && cc_o == 0 && !wr_o && !done_o, "R1", "reset state",
            {27'h0, quo_o, cc_o, wr_o}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(quo_o == 0 && cc_o == 0 && !wr_o && !done_o, "R1", "after release",
            {27'h0, quo_o, cc_o, done_o}, 64'h0);

      run_op(32'h4110_0000, 32'h4110_0000, 0, "R5");  // 1/1
      run_op(32'h4110_0000, 32'h4130_0000, 0, "R5");  // 1/3 truncates
      run_op(32'h4120_0000, 32'h4130_0000, 0, "R6");  // 2/3 rounds up
      run_op(32'hC120_0000, 32'h4130_0000, 0, "R6");  // negative result
      run_op(32'h4201_0000, 32'h4110_0000, 0, "R2");  // unnormalized dividend
      run_op(32'h4110_0000, 32'h4300_1000, 0, "R2");  // unnormalized divisor
      run_op(32'h0001_0000, 32'h4010_0000, 0, "R2");  // normalizes into underflow
      run_op(32'h4110_0000, 32'h4100_0000, 0, "R3");  // zero divisor
      run_op(32'h0000_0000, 32'h8000_0000, 0, "R3");  // 0/0
      run_op(32'hC100_0000, 32'h4120_0000, 0, "R4");  // signed zero dividend
      run_op(32'h7F10_0000, 32'h4010_0000, 0, "R7");  // overflow after adjust
      run_op(32'h7F10_0000, 32'h4020_0000, 0, "R5");  // exponent 127 fits
      run_op(32'hFF10_0000, 32'h0110_0000, 0, "R7");  // negative overflow
      run_op(32'h0010_0000, 32'h7F10_0000, 0, "R8");  // underflow
      run_op(32'h0010_0000, 32'h4020_0000, 0, "R5");  // exponent 0 fits
      run_op(32'h40FF_FFFF, 32'h4010_0001, 0, "R12"); // many subtractions
      run_op(32'h41FF_FFFF, 32'h4110_0000, 1, "R11"); // start while busy

      for (int i = 0; i < 300; i++) begin
         a = $urandom;
         b = $urandom;
         if (i % 2 == 0) begin
            a[30:24] = 7'(56 + $urandom_range(0, 16));
            b[30:24] = 7'(56 + $urandom_range(0, 16));
         end
         if (i % 16 == 3) a[23:0] = a[23:0] & 24'h00_FFFF;
         if (i % 19 == 4) b[23:0] = b[23:0] & 24'h00_0FFF;
         if (i % 37 == 5) b[23:0] = 24'h0;
         if (i % 41 == 7) a[23:0] = 24'h0;
         run_op(a, b, (i % 10 == 1), "");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule